// File: doc/BRIEF.md
# Interval Timer Host Bus Decoder

This block is the processor-facing front end of a three-channel interval timer. A host drives an 8-bit write bus, a two-bit register address, and active-low select, read and write strobes. The block works out which of the three counter channels, or the write-only configuration port, an access is meant for. It then issues single-cycle commands to the channels over a decoded command bus.

Write strobes are asynchronous to the timer clock. Each one passes through a synchroniser, and its effect is taken at the strobe's trailing (rising) edge. A write to a channel address hands the byte to that channel. A write to the configuration port is split into four fields: target, byte format, counting mode and decimal flag. Depending on those fields, the write becomes one of three commands: reprogram the target channel, freeze its count for reading, or a status read-back request that covers several channels. Reads return the addressed channel's byte directly. The end of a read is reported to that channel so it can step to its next byte. The counting elements, output waveforms and pad drivers are outside this block.

Top module: `tmr_busif`

## Requirements
- R1: Address 00, 01 and 10 select channels 0, 1 and 2. A selected data write pulses `ch_load` bit k and presents the byte on `ch_wbyte`. A selected read shows slice k of `ch_rdata` on `dout` while the read strobe is low, and pulses `ch_rdack` bit k after the strobe ends.
- R2: With `cs_n` high, both strobes are ignored: no command pulse, no register change, and `dout` is 00.
- R3: A read at address 11 returns 00 on `dout` and produces no pulse of any kind.
- R4: A configuration byte (address 11) is split as target = bits 7:6, format = bits 5:4, mode = bits 3:1 and decimal flag = bit 0. For target 00–10 with a non-zero format, it pulses `ch_prog` for that target and updates `cfg_fmt` (01 low byte only, 10 high byte only, 11 low then high) and `cfg_bcd`.
- R5: The mode code is presented on `cfg_mode` as 0–5 for codes 000–101. Codes 110 and 111 are reported as 2 and 3.
- R6: A target field of 11 is a read-back command. It pulses `rdbk_go` and presents bits 5:0 on `rdbk_sel`. No channel command is produced, and the configuration outputs keep their values.
- R7: A format field of 00 is a count-freeze command. It pulses `ch_latch` for the target channel and leaves `cfg_mode`, `cfg_fmt` and `cfg_bcd` unchanged.
- R8: A write or read acts on the rising edge of its strobe. The resulting pulse lasts one clock and appears SYNC_STAGES+1 clock edges after that strobe edge.
- R9: After reset, every pulse output and every held output (`ch_wbyte`, `cfg_*`, `rdbk_sel`) is zero.
- R10: A strobe held low for many cycles produces exactly one pulse, after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| ch_rdata | input | NCH*8 | Byte each channel offers for reading |
| ch_load | output | NCH | Data byte written to channel (pulse) |
| ch_wbyte | output | 8 | Last data byte written |
| ch_prog | output | NCH | Reprogram channel (pulse) |
| cfg_mode | output | 3 | Normalised counting mode 0–5 |
| cfg_fmt | output | 2 | Byte format of last reprogram |
| cfg_bcd | output | 1 | Decimal counting flag of last reprogram |
| ch_latch | output | NCH | Freeze channel count (pulse) |
| rdbk_go | output | 1 | Read-back command (pulse) |
| rdbk_sel | output | 6 | Read-back command bits |
| ch_rdack | output | NCH | Read of channel finished (pulse) |

## Verification
The hardest condition to reach is the trailing-edge decision when the strobe has stayed low for a long time. The decoded command must come from the fields captured while the strobe was low, and it must appear exactly once, only after the strobe is released. The stimulus covers this by holding a configuration write low for a dozen clocks. It also places a freeze command and a read-back command between two reprogram writes. The configuration outputs must then keep the first reprogram's values through both. Deselected accesses and control-port reads are placed right after valid ones. Any stray pulse would therefore land inside the window the reference model is watching.

// File: rtl/tmr_busif_pkg.sv
`timescale 1ns/1ps
package tmr_busif_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 2'b11;
  localparam logic [1:0]        SEL_RDBK = 2'b11;

  typedef enum logic [1:0] {
    FMT_FREEZE = 2'b00,
    FMT_LO     = 2'b01,
    FMT_HI     = 2'b10,
    FMT_BOTH   = 2'b11
  } byte_fmt_e;

  typedef struct packed {
    logic [1:0] target;
    byte_fmt_e  fmt;
    logic [2:0] mode;
    logic       bcd;
  } cfg_byte_t;

  // Codes with the middle bit set fold onto modes 2 and 3.
  function automatic logic [2:0] fold_mode(input logic [2:0] code);
    return code[1] ? {1'b0, code[1:0]} : code;
  endfunction
endpackage

// File: rtl/tmr_strobe_sync.sv
`timescale 1ns/1ps
module tmr_strobe_sync #(
  parameter int STAGES = 2,
  parameter int CW     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic [CW-1:0] cap_in,
  output logic          rise,
  output logic [CW-1:0] cap_out
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              dly_q;
  logic [CW-1:0]     cap_q, cap_d;
  logic              cap_en;
  logic              lvl;

  assign lvl = chain_q[STAGES-1];

  always_comb begin
    chain_d[0] = strobe_n;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  assign cap_en = ~lvl;
  assign cap_d  = cap_en ? cap_in : cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      dly_q   <= 1'b1;
      cap_q   <= '0;
    end else begin
      chain_q <= chain_d;
      dly_q   <= lvl;
      cap_q   <= cap_d;
    end
  end

  assign rise    = lvl & ~dly_q;
  assign cap_out = cap_q;
endmodule

// File: rtl/tmr_ctl_decode.sv
`timescale 1ns/1ps
module tmr_ctl_decode
  import tmr_busif_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              fire,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  data,
  output logic [NCH-1:0]    load,
  output logic [NCH-1:0]    prog,
  output logic [NCH-1:0]    latch,
  output logic              rdbk,
  output logic [2:0]        mode,
  output logic [1:0]        fmt,
  output logic              bcd,
  output logic [5:0]        rsel
);
  cfg_byte_t cb;
  logic      hit, ctl_hit;

  assign cb      = cfg_byte_t'(data);
  assign hit     = fire & ~sel_n;
  assign ctl_hit = hit & (addr == CTL_ADDR);
  assign rdbk    = ctl_hit & (cb.target == SEL_RDBK);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [1:0] CODE = 2'(i);
    assign load[i]  = hit & (addr == CODE);
    assign latch[i] = ctl_hit & (cb.target == CODE) & (cb.fmt == FMT_FREEZE);
    assign prog[i]  = ctl_hit & (cb.target == CODE) & (cb.fmt != FMT_FREEZE);
  end

  assign mode = fold_mode(cb.mode);
  assign fmt  = cb.fmt;
  assign bcd  = cb.bcd;
  assign rsel = data[5:0];
endmodule

// File: rtl/tmr_rd_mux.sv
`timescale 1ns/1ps
module tmr_rd_mux
  import tmr_busif_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NCH*BUS_W-1:0] ch_rdata,
  output logic [BUS_W-1:0]     dout
);
  always_comb begin
    dout = '0;
    if (!cs_n && !rd_n) begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == 2'(i)) dout = ch_rdata[i*BUS_W +: BUS_W];
      end
    end
  end
endmodule

// File: rtl/tmr_busif.sv
`timescale 1ns/1ps
module tmr_busif
  import tmr_busif_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [1:0]           addr,
  input  logic [7:0]           din,
  output logic [7:0]           dout,
  input  logic [NCH*8-1:0]     ch_rdata,
  output logic [NCH-1:0]       ch_load,
  output logic [7:0]           ch_wbyte,
  output logic [NCH-1:0]       ch_prog,
  output logic [2:0]           cfg_mode,
  output logic [1:0]           cfg_fmt,
  output logic                 cfg_bcd,
  output logic [NCH-1:0]       ch_latch,
  output logic                 rdbk_go,
  output logic [5:0]           rdbk_sel,
  output logic [NCH-1:0]       ch_rdack
);
  localparam int WCAP_W = 1 + ADDR_W + BUS_W;
  localparam int RCAP_W = 1 + ADDR_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  // strobe synchronisers with field capture
  logic              wr_rise, rd_rise;
  logic [WCAP_W-1:0] wcap;
  logic [RCAP_W-1:0] rcap;

  tmr_strobe_sync #(.STAGES(SYNC_STAGES), .CW(WCAP_W)) u_wsync (
    .clk(clk), .rst_n(rst_int_n), .strobe_n(wr_n),
    .cap_in({cs_n, addr, din}), .rise(wr_rise), .cap_out(wcap)
  );

  tmr_strobe_sync #(.STAGES(SYNC_STAGES), .CW(RCAP_W)) u_rsync (
    .clk(clk), .rst_n(rst_int_n), .strobe_n(rd_n),
    .cap_in({cs_n, addr}), .rise(rd_rise), .cap_out(rcap)
  );

  // write decode
  logic [NCH-1:0] dec_load, dec_prog, dec_latch, dec_rdack;
  logic           dec_rdbk, dec_bcd;
  logic [2:0]     dec_mode;
  logic [1:0]     dec_fmt;
  logic [5:0]     dec_rsel;

  tmr_ctl_decode #(.NCH(NCH)) u_dec (
    .fire(wr_rise), .sel_n(wcap[WCAP_W-1]),
    .addr(wcap[BUS_W +: ADDR_W]), .data(wcap[BUS_W-1:0]),
    .load(dec_load), .prog(dec_prog), .latch(dec_latch), .rdbk(dec_rdbk),
    .mode(dec_mode), .fmt(dec_fmt), .bcd(dec_bcd), .rsel(dec_rsel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_rdack
    assign dec_rdack[i] = rd_rise & ~rcap[RCAP_W-1] & (rcap[ADDR_W-1:0] == 2'(i));
  end

  // read data path
  tmr_rd_mux #(.NCH(NCH)) u_rmux (
    .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .ch_rdata(ch_rdata), .dout(dout)
  );

  // next state
  logic [NCH-1:0] load_q, prog_q, latch_q, rdack_q;
  logic           rdbk_q, bcd_q, bcd_d;
  logic [7:0]     wbyte_q, wbyte_d;
  logic [2:0]     mode_q, mode_d;
  logic [1:0]     fmt_q, fmt_d;
  logic [5:0]     rsel_q, rsel_d;
  logic           cfg_en, wbyte_en, rsel_en;

  always_comb begin
    cfg_en   = |dec_prog;
    wbyte_en = |dec_load;
    rsel_en  = dec_rdbk;
    mode_d   = cfg_en   ? dec_mode              : mode_q;
    fmt_d    = cfg_en   ? dec_fmt               : fmt_q;
    bcd_d    = cfg_en   ? dec_bcd               : bcd_q;
    wbyte_d  = wbyte_en ? wcap[BUS_W-1:0]       : wbyte_q;
    rsel_d   = rsel_en  ? dec_rsel              : rsel_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      load_q  <= '0;
      prog_q  <= '0;
      latch_q <= '0;
      rdack_q <= '0;
      rdbk_q  <= 1'b0;
      mode_q  <= '0;
      fmt_q   <= '0;
      bcd_q   <= 1'b0;
      wbyte_q <= '0;
      rsel_q  <= '0;
    end else begin
      load_q  <= dec_load;
      prog_q  <= dec_prog;
      latch_q <= dec_latch;
      rdack_q <= dec_rdack;
      rdbk_q  <= dec_rdbk;
      mode_q  <= mode_d;
      fmt_q   <= fmt_d;
      bcd_q   <= bcd_d;
      wbyte_q <= wbyte_d;
      rsel_q  <= rsel_d;
    end
  end

  assign ch_load  = load_q;
  assign ch_wbyte = wbyte_q;
  assign ch_prog  = prog_q;
  assign cfg_mode = mode_q;
  assign cfg_fmt  = fmt_q;
  assign cfg_bcd  = bcd_q;
  assign ch_latch = latch_q;
  assign rdbk_go  = rdbk_q;
  assign rdbk_sel = rsel_q;
  assign ch_rdack = rdack_q;
endmodule

// File: rtl/tmr_busif_chk.sv
`timescale 1ns/1ps
module tmr_busif_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic [1:0]     addr,
  input logic [7:0]     dout,
  input logic [NCH-1:0] ch_load,
  input logic [NCH-1:0] ch_prog,
  input logic [NCH-1:0] ch_latch,
  input logic           rdbk_go,
  input logic [2:0]     cfg_mode,
  input logic [1:0]     cfg_fmt,
  input logic           cfg_bcd
);
  p_deselect_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dout == 8'h00));

  p_ctl_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && addr == 2'b11) |-> (dout == 8'h00));

  p_prog_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_prog));

  p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode <= 3'd5);

  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|ch_load, |ch_prog, |ch_latch, rdbk_go}) <= 1);

  p_latch_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_latch));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_prog == '0) |-> $stable({cfg_mode, cfg_fmt, cfg_bcd}));

  p_prog_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_prog != '0) |=> (ch_prog == '0));

  p_rdbk_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk_go |=> !rdbk_go);
endmodule

bind tmr_busif tmr_busif_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .dout(dout),
  .ch_load(ch_load), .ch_prog(ch_prog), .ch_latch(ch_latch),
  .rdbk_go(rdbk_go), .cfg_mode(cfg_mode), .cfg_fmt(cfg_fmt), .cfg_bcd(cfg_bcd)
);

// File: tb/tmr_busif_bench.sv
`timescale 1ns/1ps
module tmr_busif_bench;
  localparam int NCH = 3;
  localparam int SS  = 2;
  localparam int LAT = SS + 1;

  logic           clk, rst_n, cs_n, rd_n, wr_n;
  logic [1:0]     addr;
  logic [7:0]     din, dout, ch_wbyte;
  logic [NCH*8-1:0] ch_rdata;
  logic [NCH-1:0] ch_load, ch_prog, ch_latch, ch_rdack;
  logic [2:0]     cfg_mode;
  logic [1:0]     cfg_fmt;
  logic           cfg_bcd, rdbk_go;
  logic [5:0]     rdbk_sel;

  tmr_busif #(.NCH(NCH), .SYNC_STAGES(SS)) u_tmr_busif (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .ch_rdata(ch_rdata),
    .ch_load(ch_load), .ch_wbyte(ch_wbyte), .ch_prog(ch_prog),
    .cfg_mode(cfg_mode), .cfg_fmt(cfg_fmt), .cfg_bcd(cfg_bcd),
    .ch_latch(ch_latch), .rdbk_go(rdbk_go), .rdbk_sel(rdbk_sel),
    .ch_rdack(ch_rdack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_chk = 0, n_err = 0, cyc = 0;
  string phase = "R9 reset";

  // reference model state
  int          ev_due[$];
  logic [11:0] ev_info[$];   // {is_read, cs_n, addr, data}
  logic [NCH-1:0] e_load, e_prog, e_latch, e_rdack;
  logic        e_rdbk, e_bcd;
  logic [7:0]  e_wbyte;
  logic [2:0]  e_mode;
  logic [1:0]  e_fmt;
  logic [5:0]  e_rsel;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s / %s: actual=%0h expected=%0h (cycle %0d)", phase, what, act, exp, cyc);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic apply_ev(input logic [11:0] e);
    logic       is_rd = e[11];
    logic       sn    = e[10];
    logic [1:0] a     = e[9:8];
    logic [7:0] d     = e[7:0];
    if (sn) return;                      // R2: deselected strobes do nothing
    if (is_rd) begin
      if (a != 2'b11) e_rdack[a] = 1'b1; // R3: control reads have no effect
    end else if (a != 2'b11) begin
      e_load[a] = 1'b1;
      e_wbyte   = d;
    end else if (d[7:6] == 2'b11) begin
      e_rdbk = 1'b1;
      e_rsel = d[5:0];
    end else if (d[5:4] == 2'b00) begin
      e_latch[d[7:6]] = 1'b1;
    end else begin
      e_prog[d[7:6]] = 1'b1;
      e_fmt  = d[5:4];
      e_bcd  = d[0];
      e_mode = d[2] ? {1'b0, d[2:1]} : d[3:1];
    end
  endtask

  // per-cycle compare, sampled 1 ns after the rising edge
  initial begin
    e_wbyte = '0; e_mode = '0; e_fmt = '0; e_bcd = 1'b0; e_rsel = '0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      e_load = '0; e_prog = '0; e_latch = '0; e_rdack = '0; e_rdbk = 1'b0;
      if (!rst_n) begin
        e_wbyte = '0; e_mode = '0; e_fmt = '0; e_bcd = 1'b0; e_rsel = '0;
      end
      while (ev_due.size() > 0 && ev_due[0] == cyc) begin
        void'(ev_due.pop_front());
        apply_ev(ev_info.pop_front());
      end
      chk("R1 ch_load", 32'(ch_load), 32'(e_load));
      chk("R1 ch_wbyte", 32'(ch_wbyte), 32'(e_wbyte));
      chk("R1 ch_rdack", 32'(ch_rdack), 32'(e_rdack));
      chk("R1 dout", 32'(dout),
          32'((!cs_n && !rd_n && addr != 2'b11) ? ch_rdata[addr*8 +: 8] : 8'h00));
      chk("R4 ch_prog", 32'(ch_prog), 32'(e_prog));
      chk("R4 cfg_fmt", 32'(cfg_fmt), 32'(e_fmt));
      chk("R4 cfg_bcd", 32'(cfg_bcd), 32'(e_bcd));
      chk("R5 cfg_mode", 32'(cfg_mode), 32'(e_mode));
      chk("R7 ch_latch", 32'(ch_latch), 32'(e_latch));
      chk("R6 rdbk_go", 32'(rdbk_go), 32'(e_rdbk));
      chk("R6 rdbk_sel", 32'(rdbk_sel), 32'(e_rsel));
      if (cyc > 20000) begin
        n_err++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
        report();
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sn, input int low);
    @(negedge clk); cs_n = sn; addr = a; din = d;
    @(negedge clk); wr_n = 1'b0;
    repeat (low) @(negedge clk);
    wr_n = 1'b1;
    ev_due.push_back(cyc + LAT);
    ev_info.push_back({1'b0, sn, a, d});
    repeat (LAT + 2) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic sn, input int low);
    @(negedge clk); cs_n = sn; addr = a;
    @(negedge clk); rd_n = 1'b0;
    repeat (low) @(negedge clk);
    rd_n = 1'b1;
    ev_due.push_back(cyc + LAT);
    ev_info.push_back({1'b1, sn, a, 8'h00});
    repeat (LAT + 2) @(negedge clk);
    cs_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = 2'b00; din = 8'h00; ch_rdata = 24'hC2_B1_A0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    phase = "R1 R8 channel data";
    bus_wr(2'b00, 8'h5A, 1'b0, 2);
    bus_wr(2'b01, 8'h3C, 1'b0, 3);
    bus_wr(2'b10, 8'hF0, 1'b0, 2);
    bus_rd(2'b00, 1'b0, 3);
    bus_rd(2'b01, 1'b0, 2);
    ch_rdata = 24'h7E_96_11;
    bus_rd(2'b10, 1'b0, 4);

    phase = "R4 R5 reprogram";
    bus_wr(2'b11, 8'h77, 1'b0, 2);  // ch1, low-then-high, mode 3, decimal
    bus_wr(2'b11, 8'h9C, 1'b0, 2);  // ch2, low only, code 110 -> mode 2
    bus_wr(2'b11, 8'h2F, 1'b0, 2);  // ch0, high only, code 111 -> mode 3
    bus_wr(2'b11, 8'h38, 1'b0, 2);  // mode 4
    bus_wr(2'b11, 8'h3B, 1'b0, 2);  // mode 5, decimal
    bus_wr(2'b11, 8'h32, 1'b0, 2);  // mode 1
    bus_wr(2'b11, 8'h56, 1'b0, 2);  // ch1, low only, code 011

    phase = "R7 count freeze";
    bus_wr(2'b11, 8'h40, 1'b0, 2);
    bus_wr(2'b11, 8'h8E, 1'b0, 2);
    bus_wr(2'b11, 8'h01, 1'b0, 2);

    phase = "R6 read-back";
    bus_wr(2'b11, 8'hE5, 1'b0, 2);
    bus_wr(2'b11, 8'hFF, 1'b0, 2);

    phase = "R2 deselected";
    bus_wr(2'b00, 8'h12, 1'b1, 2);
    bus_wr(2'b11, 8'h34, 1'b1, 2);
    bus_rd(2'b01, 1'b1, 3);

    phase = "R3 control read";
    bus_rd(2'b11, 1'b0, 3);

    phase = "R10 long strobe";
    bus_wr(2'b11, 8'h96, 1'b0, 12);
    bus_wr(2'b01, 8'hA5, 1'b0, 10);
    bus_rd(2'b00, 1'b0, 11);

    repeat (8) @(negedge clk);
    report();
  end
endmodule